// File: doc/BRIEF.md
# SPI Master Shift Engine

This block drives an SPI bus as its master. It pulls transmit words from a valid/ready source, shifts them out on MOSI and delivers the words it shifts in from MISO to a valid/ready sink. A programmable divider derives the serial clock from the reference clock. The word length, clock polarity, clock phase, bit order and a gap between words are set by configuration inputs. These inputs are captured when a transfer starts.

A transfer is defined by two word counts, one per direction, and each direction has its own enable. The engine shifts as many words as the larger active count. It raises a one-cycle completion pulse for each direction once that direction's last counted word has been fully shifted. The single chip-select output either follows the transfer automatically or copies a software pin value. The block stalls at a word boundary when transmit data is missing or the receive sink is still full. During a stall it keeps SCK at its idle level.

Top module: `spi_shift_engine`

## Requirements
- R1: After reset, and whenever no transfer runs, SCK equals `cpol_i`, automatic chip select is high, MOSI equals `mosi_idle_i`, and `tx_ready_o`, `rx_valid_o`, `tx_done_o` and `rx_done_o` are low.
- R2: Each bit takes two half phases of D reference clocks each, where D is `clk_div_i` and a value of 0 counts as 1. Consecutive sampling edges inside one word are therefore 2·D clocks apart.
- R3: SCK idles at CPOL. When CPHA is 0, MISO is sampled on the leading edge (idle to active). When CPHA is 1, it is sampled on the trailing edge. MOSI changes only at the start of a bit and is stable at the sampling edge.
- R4: A word has L bits, with L = `word_len_i`, except that 0 or any value above 32 gives L = 32. Bit L-1 goes first when `lsb_first_i` is 0, and bit 0 goes first when it is 1. Transmit bits at L and above are ignored.
- R5: A received word is presented right-aligned in `rx_data_o` with its upper bits zero. It stays valid and unchanged until `rx_ready_i` accepts it.
- R6: A direction is active when its enable is set and its count is nonzero. The transfer shifts max(active tx count, active rx count) words and consumes exactly the active tx count of source words. With no active direction, SCK never toggles.
- R7: MOSI holds `mosi_idle_i` during any word that is not a counted transmit word, which covers both transmit disabled and transmit count used up.
- R8: Each active direction produces exactly one single-cycle done pulse. The pulse is seen D clocks after the sampling edge of the last bit of that direction's final word. An inactive direction produces no pulse.
- R9: Between words, the sampling edges are 2·D + G + 1 clocks apart, where G is `gap_i`. This is a gap of G clocks plus one load cycle, with no gap state when G is 0.
- R10: At a word boundary, the engine waits with SCK at its idle level and does not shift while transmit data is needed but `tx_valid_i` is low, or while the previous received word is still unaccepted.
- R11: A transfer starts when `run_i` is high in idle. After completion it holds without restarting until `run_i` drops. Dropping `run_i` at any time aborts the transfer and returns the engine to idle on the next cycle.
- R12: When `cs_auto_i` is 1, `cs_no` is low from the start of the transfer until the last word ends. When `cs_auto_i` is 0, `cs_no` follows `cs_pin_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Start (high) / abort (low) |
| cpol_i | input | 1 | SCK idle level |
| cpha_i | input | 1 | Sample on trailing edge when 1 |
| lsb_first_i | input | 1 | Bit 0 first when 1 |
| word_len_i | input | 6 | Bits per word, 1 to 32 |
| clk_div_i | input | 11 | Reference clocks per SCK half phase |
| gap_i | input | 16 | Reference clocks between words |
| tx_en_i | input | 1 | Transmit direction enable |
| rx_en_i | input | 1 | Receive direction enable |
| tx_count_i | input | 32 | Transmit word count |
| rx_count_i | input | 32 | Receive word count |
| cs_auto_i | input | 1 | Chip select driven by the engine when 1 |
| cs_pin_i | input | 1 | Chip select level in software mode |
| mosi_idle_i | input | 1 | MOSI level when not transmitting |
| tx_data_i | input | 32 | Transmit word |
| tx_valid_i | input | 1 | Transmit word valid |
| tx_ready_o | output | 1 | Transmit word taken |
| rx_data_o | output | 32 | Received word |
| rx_valid_o | output | 1 | Received word valid |
| rx_ready_i | input | 1 | Sink accepts received word |
| tx_done_o | output | 1 | Transmit completion pulse |
| rx_done_o | output | 1 | Receive completion pulse |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| cs_no | output | 1 | Chip select, active low |
| miso_i | input | 1 | Serial data in |

## Verification
The bench runs a serial slave model that records MOSI and advances MISO on each sampling edge for all four clock modes. It uses odd word lengths and the out-of-range length codes, so a design that sampled on the wrong edge or reversed the bit order returns rotated or mirrored words. Unequal transmit and receive counts, together with a disabled direction, expose a design that keeps driving stale data after its transmit count runs out or that pulses done for an idle direction. Exact spacing between sampling edges is checked at the divider maximum and with large and zero gaps, which catches an off-by-one half phase or a missing load cycle. Random gaps in source valid and sink ready show whether SCK keeps toggling during a stall or whether a received word is lost. An abort in mid-word checks that the engine returns to idle at once.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SHIFT,
    ST_GAP,
    ST_DONE
  } eng_state_e;
endpackage

// File: rtl/spi_eng_timer.sv
module spi_eng_timer #(
  parameter int unsigned W = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] limit_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] lim;

  // a limit of zero behaves as one
  assign lim      = (limit_i == '0) ? W'(1) : limit_i;
  assign expire_o = en_i && (cnt_q == lim - W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || expire_o) cnt_q <= '0;
    else                        cnt_q <= cnt_q + W'(1);
  end

  AST_CNT_BELOW_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> cnt_q < lim); // R2
endmodule

// File: rtl/spi_eng_shifter.sv
module spi_eng_shifter #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LEN_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] tx_word_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              lsb_first_i,
  input  logic              sample_i,
  input  logic              advance_i,
  input  logic              miso_i,
  output logic              tx_bit_o,
  output logic              last_bit_o,
  output logic [DATA_W-1:0] rx_word_o
);
  localparam int unsigned BIT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] tx_q, rx_q;
  logic [BIT_W-1:0]  bit_q;
  logic [LEN_W-1:0]  pos_wide;
  logic [BIT_W-1:0]  pos;

  // bits are addressed in place instead of shifted
  assign pos_wide   = lsb_first_i ? LEN_W'(bit_q)
                                  : len_i - LEN_W'(1) - LEN_W'(bit_q);
  assign pos        = pos_wide[BIT_W-1:0];
  assign tx_bit_o   = tx_q[pos];
  assign last_bit_o = (LEN_W'(bit_q) == len_i - LEN_W'(1));
  assign rx_word_o  = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q  <= '0;
      rx_q  <= '0;
      bit_q <= '0;
    end else if (load_i) begin
      tx_q  <= tx_word_i;
      rx_q  <= '0;
      bit_q <= '0;
    end else begin
      if (sample_i)  rx_q[pos] <= miso_i;
      if (advance_i) bit_q     <= bit_q + BIT_W'(1);
    end
  end

  AST_BIT_IN_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i || advance_i) |-> LEN_W'(bit_q) < len_i); // R4
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_eng_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DIV_W  = 11,
  parameter int unsigned GAP_W  = 16,
  parameter int unsigned CNT_W  = 32,
  localparam int unsigned LEN_W = $clog2(DATA_W) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              lsb_first_i,
  input  logic [LEN_W-1:0]  word_len_i,
  input  logic [DIV_W-1:0]  clk_div_i,
  input  logic [GAP_W-1:0]  gap_i,
  input  logic              tx_en_i,
  input  logic              rx_en_i,
  input  logic [CNT_W-1:0]  tx_count_i,
  input  logic [CNT_W-1:0]  rx_count_i,
  input  logic              cs_auto_i,
  input  logic              cs_pin_i,
  input  logic              mosi_idle_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  output logic              tx_done_o,
  output logic              rx_done_o,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              cs_no,
  input  logic              miso_i
);
  typedef struct packed {
    logic             cpol;
    logic             cpha;
    logic             lsb;
    logic [LEN_W-1:0] len;
    logic [DIV_W-1:0] div;
    logic [GAP_W-1:0] gap;
  } eng_cfg_t;

  eng_state_e        st_q, st_d;
  eng_cfg_t          cfg_q, cfg_in;
  logic [CNT_W-1:0]  tx_rem_q, rx_rem_q;
  logic              half_q;
  logic              rx_valid_q;
  logic [DATA_W-1:0] rx_data_q;
  logic              tx_done_q, rx_done_q;

  logic              tx_need, rx_need, rx_ok, load_go, more;
  logic              half_exp, gap_exp, mid_edge, word_end, bit_adv;
  logic              tx_bit, last_bit, any_active;
  logic [DATA_W-1:0] rx_word;
  logic [LEN_W-1:0]  len_eff;

  assign len_eff = (word_len_i == '0 || word_len_i > LEN_W'(DATA_W))
                 ? LEN_W'(DATA_W) : word_len_i;

  always_comb begin
    cfg_in      = cfg_q;
    cfg_in.cpol = cpol_i;
    cfg_in.cpha = cpha_i;
    cfg_in.lsb  = lsb_first_i;
    cfg_in.len  = len_eff;
    cfg_in.div  = clk_div_i;
    cfg_in.gap  = gap_i;
  end

  assign any_active = (tx_en_i && tx_count_i != '0) || (rx_en_i && rx_count_i != '0);
  assign tx_need    = (tx_rem_q != '0);
  assign rx_need    = (rx_rem_q != '0);
  // receive sink must be free before the next word is started
  assign rx_ok      = !rx_need || !rx_valid_q || rx_ready_i;
  assign load_go    = (st_q == ST_LOAD) && rx_ok && (!tx_need || tx_valid_i);
  assign more       = (tx_rem_q > CNT_W'(1)) || (rx_rem_q > CNT_W'(1));

  assign mid_edge = (st_q == ST_SHIFT) && half_exp && !half_q;
  assign word_end = (st_q == ST_SHIFT) && half_exp &&  half_q &&  last_bit;
  assign bit_adv  = (st_q == ST_SHIFT) && half_exp &&  half_q && !last_bit;

  spi_eng_timer #(.W(DIV_W)) i_half_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (st_q == ST_SHIFT),
    .limit_i  (cfg_q.div),
    .expire_o (half_exp)
  );

  spi_eng_timer #(.W(GAP_W)) i_gap_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (st_q == ST_GAP),
    .limit_i  (cfg_q.gap),
    .expire_o (gap_exp)
  );

  spi_eng_shifter #(.DATA_W(DATA_W), .LEN_W(LEN_W)) i_shifter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_go),
    .tx_word_i   (tx_data_i),
    .len_i       (cfg_q.len),
    .lsb_first_i (cfg_q.lsb),
    .sample_i    (mid_edge),
    .advance_i   (bit_adv),
    .miso_i      (miso_i),
    .tx_bit_o    (tx_bit),
    .last_bit_o  (last_bit),
    .rx_word_o   (rx_word)
  );

  always_comb begin
    st_d = st_q;
    if (!run_i) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE:  st_d = any_active ? ST_LOAD : ST_DONE;
        ST_LOAD:  if (load_go) st_d = ST_SHIFT;
        ST_SHIFT: if (word_end)
                    st_d = !more ? ST_DONE : (cfg_q.gap != '0) ? ST_GAP : ST_LOAD;
        ST_GAP:   if (gap_exp) st_d = ST_LOAD;
        default:  st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cfg_q      <= '{cpol: 1'b0, cpha: 1'b0, lsb: 1'b0, len: LEN_W'(DATA_W),
                      div: DIV_W'(1), gap: '0};
      tx_rem_q   <= '0;
      rx_rem_q   <= '0;
      half_q     <= 1'b0;
      rx_valid_q <= 1'b0;
      rx_data_q  <= '0;
      tx_done_q  <= 1'b0;
      rx_done_q  <= 1'b0;
    end else begin
      st_q      <= st_d;
      tx_done_q <= 1'b0;
      rx_done_q <= 1'b0;
      if (rx_valid_q && rx_ready_i) rx_valid_q <= 1'b0;
      if (!run_i) begin
        rx_valid_q <= 1'b0;
        half_q     <= 1'b0;
      end else begin
        unique case (st_q)
          ST_IDLE: begin
            cfg_q    <= cfg_in;
            tx_rem_q <= tx_en_i ? tx_count_i : '0;
            rx_rem_q <= rx_en_i ? rx_count_i : '0;
          end
          ST_LOAD: half_q <= 1'b0;
          ST_SHIFT: begin
            if (half_exp) half_q <= !half_q;
            if (word_end) begin
              if (tx_need) tx_rem_q <= tx_rem_q - CNT_W'(1);
              if (rx_need) begin
                rx_rem_q   <= rx_rem_q - CNT_W'(1);
                rx_valid_q <= 1'b1;
                rx_data_q  <= rx_word;
              end
              tx_done_q <= (tx_rem_q == CNT_W'(1));
              rx_done_q <= (rx_rem_q == CNT_W'(1));
            end
          end
          default: ;
        endcase
      end
    end
  end

  // leading half is the active level only when sampling on the trailing edge
  always_comb begin
    if (st_q == ST_SHIFT)     sck_o = cfg_q.cpol ^ half_q ^ cfg_q.cpha;
    else if (st_q == ST_IDLE) sck_o = cpol_i;
    else                      sck_o = cfg_q.cpol;
  end

  assign mosi_o     = (st_q == ST_SHIFT && tx_need) ? tx_bit : mosi_idle_i;
  assign cs_no      = cs_auto_i ? !(st_q == ST_LOAD || st_q == ST_SHIFT || st_q == ST_GAP)
                                : cs_pin_i;
  assign tx_ready_o = (st_q == ST_LOAD) && tx_need && rx_ok;
  assign rx_valid_o = rx_valid_q;
  assign rx_data_o  = rx_data_q;
  assign tx_done_o  = tx_done_q;
  assign rx_done_o  = rx_done_q;

  AST_ABORT_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> st_q == ST_IDLE); // R11
  AST_TX_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |=> !tx_done_o); // R8
  AST_RX_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o |=> !rx_done_o); // R8
  AST_RX_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !rx_ready_i && run_i) |=> rx_valid_o && $stable(rx_data_o)); // R5
  AST_MOSI_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SHIFT && half_q && tx_need) |-> $stable(mosi_o)); // R3
  AST_READY_NEEDS_SINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> !(rx_valid_o && !rx_ready_i && rx_need)); // R10
endmodule

// File: tb/test_spi_shift_engine.sv
`timescale 1ns/1ps
module test_spi_shift_engine;
  localparam int DATA_W = 32, DIV_W = 11, GAP_W = 16, CNT_W = 32, LEN_W = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic run = 0, cpol = 0, cpha = 0, lsb = 0;
  logic [LEN_W-1:0] wl = 8;
  logic [DIV_W-1:0] div = 1;
  logic [GAP_W-1:0] gap = 0;
  logic txen = 0, rxen = 0;
  logic [CNT_W-1:0] txc = 0, rxc = 0;
  logic cs_auto = 1, cs_pin = 1, mosi_idle = 0;
  logic [31:0] txd = 0;
  logic txv = 0, rxr = 1, miso = 0;
  logic txr, rxv, txdone, rxdone, sck, mosi, csn;
  logic [31:0] rxd;

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [31:0] tx_words [0:15];
  logic [31:0] rx_got   [0:15];
  bit          mstream  [0:1023];
  bit          mosi_rec [0:1023];
  int          stime    [0:1023];

  spi_shift_engine #(.DATA_W(DATA_W), .DIV_W(DIV_W), .GAP_W(GAP_W), .CNT_W(CNT_W)) i_spi_shift_engine (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .cpol_i(cpol), .cpha_i(cpha),
    .lsb_first_i(lsb), .word_len_i(wl), .clk_div_i(div), .gap_i(gap),
    .tx_en_i(txen), .rx_en_i(rxen), .tx_count_i(txc), .rx_count_i(rxc),
    .cs_auto_i(cs_auto), .cs_pin_i(cs_pin), .mosi_idle_i(mosi_idle),
    .tx_data_i(txd), .tx_valid_i(txv), .tx_ready_o(txr),
    .rx_data_o(rxd), .rx_valid_o(rxv), .rx_ready_i(rxr),
    .tx_done_o(txdone), .rx_done_o(rxdone),
    .sck_o(sck), .mosi_o(mosi), .cs_no(csn), .miso_i(miso)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_mosi(int s, int L, int txa, bit lsbf, bit idle);
    int k = s / L;
    int j = s % L;
    if (k >= txa) return idle;
    return lsbf ? tx_words[k][j] : tx_words[k][L-1-j];
  endfunction

  function automatic logic [31:0] exp_rx(int k, int L, bit lsbf);
    logic [31:0] w = '0;
    for (int j = 0; j < L; j++) w[lsbf ? j : L-1-j] = mstream[k*L + j];
    return w;
  endfunction

  task automatic xfer(input bit p_cpol, input bit p_cpha, input bit p_lsb, input int p_wl,
                      input int p_div, input int p_gap, input bit p_txen, input bit p_rxen,
                      input int p_txc, input int p_rxc, input bit p_idle, input bit p_stall);
    int L, D, txa, rxa, N, ns, nrx, tidx, ntxd, nrxd, txd_c, rxd_c, post;
    int bad_mosi, bad_int, bad_cs, bad_stall, bad_rx;
    bit prev_sck, tx_fire, rx_fire, samp_lvl;
    L   = (p_wl == 0 || p_wl > 32) ? 32 : p_wl;
    D   = (p_div == 0) ? 1 : p_div;
    txa = p_txen ? p_txc : 0;
    rxa = p_rxen ? p_rxc : 0;
    N   = (txa > rxa) ? txa : rxa;
    ns = 0; nrx = 0; tidx = 0; ntxd = 0; nrxd = 0; txd_c = 0; rxd_c = 0; post = 0;
    bad_mosi = 0; bad_int = 0; bad_cs = 0; bad_stall = 0; bad_rx = 0;
    samp_lvl = p_cpha ? p_cpol : !p_cpol;
    for (int i = 0; i < 16; i++) tx_words[i] = $urandom;
    for (int i = 0; i < 1024; i++) mstream[i] = 1'($urandom % 2);
    @(negedge clk);
    cpol = p_cpol; cpha = p_cpha; lsb = p_lsb; wl = LEN_W'(p_wl); div = DIV_W'(p_div);
    gap = GAP_W'(p_gap); txen = p_txen; rxen = p_rxen; txc = p_txc; rxc = p_rxc;
    mosi_idle = p_idle; miso = mstream[0]; txv = 0; rxr = 1;
    #1 prev_sck = sck;
    run = 1;
    tx_fire = 0; rx_fire = 0;
    for (int t = 0; t < 60000; t++) begin
      @(negedge clk);
      if (tx_fire) tidx++;
      if (sck !== prev_sck && sck === samp_lvl) begin
        if (ns < 1024) begin
          stime[ns] = cyc;
          if (mosi !== exp_mosi(ns, L, txa, p_lsb, p_idle)) bad_mosi++;
        end
        if (cs_auto && csn !== 1'b0) bad_cs++;
        if (!cs_auto && csn !== cs_pin) bad_cs++;
        ns++;
        miso = mstream[ns % 1024];
      end
      prev_sck = sck;
      if (txdone) begin ntxd++; txd_c = cyc; end
      if (rxdone) begin nrxd++; rxd_c = cyc; end
      if (txr && !txv && sck !== p_cpol) bad_stall++;
      if (!cs_auto && ($urandom % 4 == 0)) cs_pin = !cs_pin;
      txv = (tidx < txa) && !(p_stall && ($urandom % 3 == 0));
      txd = tx_words[tidx % 16];
      rxr = p_stall ? 1'($urandom % 2) : 1'b1;
      #1;
      tx_fire = txv && txr;
      rx_fire = rxv && rxr;
      if (rx_fire) begin
        if (nrx < 16 && nrx < rxa && rxd !== exp_rx(nrx, L, p_lsb)) bad_rx++;
        nrx++;
      end
      if (ns >= N*L && nrx >= rxa && ntxd >= (txa > 0 ? 1 : 0) && nrxd >= (rxa > 0 ? 1 : 0))
        post++;
      if (post > 2*D + 6) break;
    end
    if (!p_stall)
      for (int s = 1; s < ns && s < 1024; s++) begin
        int e = (s % L == 0) ? 2*D + 1 + p_gap : 2*D;
        if (stime[s] - stime[s-1] != e) bad_int++;
      end
    chk(ns == N*L, "R6", "sampling edges", ns, N*L);
    chk(tidx == txa, "R6", "source words consumed", tidx, txa);
    chk(bad_mosi == 0, "R4/R7", "MOSI bit mismatches", bad_mosi, 0);
    chk(nrx == rxa, "R5", "received words", nrx, rxa);
    chk(bad_rx == 0, "R5", "received word mismatches", bad_rx, 0);
    chk(ntxd == (txa > 0 ? 1 : 0), "R8", "tx done pulses", ntxd, txa > 0 ? 1 : 0);
    chk(nrxd == (rxa > 0 ? 1 : 0), "R8", "rx done pulses", nrxd, rxa > 0 ? 1 : 0);
    if (txa > 0) chk(txd_c - stime[txa*L-1] == D, "R8", "tx done delay", txd_c - stime[txa*L-1], D);
    if (rxa > 0) chk(rxd_c - stime[rxa*L-1] == D, "R8", "rx done delay", rxd_c - stime[rxa*L-1], D);
    if (!p_stall) chk(bad_int == 0, "R2/R9", "edge spacing errors", bad_int, 0);
    else          chk(bad_stall == 0, "R10", "SCK moved while stalled", bad_stall, 0);
    chk(bad_cs == 0, "R12", "chip select errors", bad_cs, 0);
    if (cs_auto) chk(csn === 1'b1, "R12", "cs after transfer", csn, 1);
    run = 0;
    @(negedge clk);
    chk(sck === p_cpol && mosi === p_idle && !txr && !rxv, "R11", "idle after run drop",
        {sck, mosi, txr, rxv}, {p_cpol, p_idle, 2'b00});
  endtask

  task automatic abort_test();
    int moves;
    bit prev;
    @(negedge clk);
    cpol = 1; cpha = 0; lsb = 0; wl = 16; div = 2; gap = 0; txen = 1; rxen = 1;
    txc = 8; rxc = 8; cs_auto = 1; mosi_idle = 1; txv = 1; txd = 32'hA5A5_5A5A; rxr = 1;
    run = 1;
    repeat (40) @(negedge clk);
    chk(csn === 1'b0, "R12", "cs low mid transfer", csn, 0);
    run = 0;
    @(negedge clk);
    chk(sck === 1'b1 && csn === 1'b1 && !txr, "R11", "abort returns idle", {sck, csn, txr}, 3'b110);
    moves = 0; prev = sck;
    repeat (20) begin
      @(negedge clk);
      if (sck !== prev || txdone || rxdone || rxv) moves++;
      prev = sck;
    end
    chk(moves == 0, "R11", "activity after abort", moves, 0);
    txv = 0;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(sck === 1'b0 && csn === 1'b1 && mosi === 1'b0 && !txr && !rxv && !txdone && !rxdone,
        "R1", "reset outputs", {sck, csn, mosi, txr, rxv}, 5'b01000);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(sck === 1'b0 && csn === 1'b1 && !txr, "R1", "idle after reset", {sck, csn, txr}, 3'b010);

    // mode 0, MSB first
    xfer(0, 0, 0, 8, 1, 0, 1, 1, 3, 3, 0, 0);
    // mode 3, LSB first, unequal counts, gap
    xfer(1, 1, 1, 13, 3, 5, 1, 1, 2, 4, 1, 0);
    // transmit disabled, length code 0 -> 32
    xfer(0, 1, 0, 0, 2, 1, 0, 1, 5, 3, 1, 0);
    // receive disabled, length code 40 -> 32
    xfer(1, 0, 1, 40, 1, 0, 1, 0, 2, 7, 0, 0);
    // no active direction: R6
    xfer(0, 0, 0, 8, 1, 0, 1, 0, 0, 4, 0, 0);
    // stalls on both sides: R10
    xfer(0, 1, 0, 5, 2, 0, 1, 1, 5, 5, 0, 1);
    // software chip select: R12
    cs_auto = 0;
    xfer(1, 0, 0, 7, 1, 2, 1, 1, 3, 3, 0, 0);
    cs_auto = 1;
    // maximum divider, divider 0, long gap: R2, R9
    xfer(0, 0, 1, 2, 2047, 0, 1, 1, 1, 1, 0, 0);
    xfer(1, 1, 0, 3, 0, 0, 1, 1, 2, 2, 1, 0);
    xfer(0, 0, 0, 4, 1, 300, 1, 1, 2, 2, 0, 0);
    // abort mid-word: R11
    abort_test();
    // constrained random
    for (int r = 0; r < 12; r++) begin
      xfer(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2), 1 + $urandom % 32,
           1 + $urandom % 4, $urandom % 6, ($urandom % 4) != 0, ($urandom % 4) != 0,
           $urandom % 7, $urandom % 7, 1'($urandom % 2), (r % 3) == 2);
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule